// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide programming front end of an eight-line interrupt controller. It sits on a two-address register port. Writes to the two addresses are sorted into initialization words and operation words. The initialization words arrive as an ordered burst. The block keeps a small stage counter that says which initialization word is due next. That counter also decides what the second address means: while no initialization is pending, a byte written there is the new line mask. While a burst is in progress, the same byte is the next setup word.

The block holds the configuration the burst produces: trigger mode, cascade mode, vector base, cascade bits and auto-EOI. It turns end-of-interrupt commands into a one-cycle strobe carrying a line number, which the priority core uses to retire in-service bits. Reads come back combinationally. The first address returns either the request or the in-service register from the core, chosen by a select flag. The second address returns the mask. Rotation, special-mask and bus-buffering subcommands are accepted and have no effect.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the mask, vector base, cascade bits, trigger mode, cascade mode and auto-EOI are all 0. The stage counter `icw_stage` is 0 (idle), `eoi_stb` is low, and address 0 reads the request register.
- R2: A write to address 0 with data bit 4 set starts initialization. It clears the mask, takes edge mode from bit 3, sets cascade mode when bit 1 is 0, and records bit 0 as "fourth word wanted". `icw_stage` becomes 1 (waiting for the vector word).
- R3: When that start word has bit 0 clear, auto-EOI is forced to 0 in the cycle after the write.
- R4: In stage 1, a write to address 1 stores the data with its low three bits cleared as the vector base. In cascade mode the stage moves to 2. Otherwise the cascade bits are cleared and the stage returns to 0, even when a fourth word was requested.
- R5: In stage 2, a write to address 1 stores the cascade bits. A master build (IS_MASTER=1) keeps all eight bits; a slave build keeps only bits 2:0. The stage moves to 3 if a fourth word was requested and to 0 otherwise.
- R6: In stage 3, a write to address 1 sets auto-EOI from data bit 1 and returns the stage to 0.
- R7: In stage 0, a write to address 1 loads the data into the mask.
- R8: A write to address 0 with bits 4:3 = 00 and bits 7:5 = 001 raises `eoi_stb` for exactly one cycle in the cycle after the write. `eoi_line` then names the highest-numbered set bit of `isr_vec` as sampled at the write. If `isr_vec` is zero, no strobe is produced.
- R9: A write to address 0 with bits 4:3 = 00 and bits 7:5 = 011 raises `eoi_stb` for one cycle with `eoi_line` equal to data bits 2:0.
- R10: Any other value of bits 7:5 in such a write (000, 010, 100, 101, 110, 111) produces no strobe and changes no mask, configuration or stage.
- R11: A write to address 0 with bits 4:3 = 01 and bit 1 set selects the address-0 read source: bit 0 = 1 selects the request register and 0 selects the in-service register. With bit 1 clear the selection is kept.
- R12: `bus_rdata` follows `bus_addr` combinationally. Address 1 gives the mask; address 0 gives the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 1 | Register address (0 or 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| req_vec | input | 8 | Request register from the priority core |
| isr_vec | input | 8 | In-service register from the priority core |
| irq_mask | output | 8 | Line mask |
| edge_mode | output | 1 | 1 = edge triggered, 0 = level |
| cascade_mode | output | 1 | 1 = cascaded controllers |
| vec_base | output | 8 | Vector base, low three bits zero |
| casc_bits | output | 8 | Slave-attached lines (master) or slave ID (slave) |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| icw_stage | output | 2 | Next initialization word: 0 idle, 1 vector, 2 cascade, 3 fourth |
| eoi_stb | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_line | output | 3 | Line retired by `eoi_stb` |

## Verification
A stage counter left in the wrong place shows at the very next address-1 write. Either the mask moves when it should not, or the vector base or cascade bits change in its place. `icw_stage` makes such a slip visible one cycle after the write that caused it. The tests walk every skip path: single mode with and without a fourth word, and cascade mode with and without it. After each burst they confirm that the mask is writable again. A wrong EOI decode shows up as a missing, extra or mis-numbered strobe in the cycle after the command, so each subcommand is checked in that cycle and in the cycle after it.

// File: rtl/pic_pkg.sv
package pic_pkg;

   // Which initialization word the sequencer expects on address 1.
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_VEC  = 2'd1,
      ST_CASC = 2'd2,
      ST_FOUR = 2'd3
   } icw_st_e;

   // Classification of one bus write.
   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_START = 3'd1,
      CMD_EOI   = 3'd2,
      CMD_RDSEL = 3'd3,
      CMD_PORT1 = 3'd4
   } cmd_kind_e;

   localparam logic [2:0] SUB_EOI_ANY  = 3'b001;
   localparam logic [2:0] SUB_EOI_LINE = 3'b011;

endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
   import pic_pkg::*;
(
   input  logic       we,
   input  logic       addr,
   input  logic [1:0] sel_bits,   // data bits 4:3
   output cmd_kind_e  kind
);

   always_comb begin
      if (!we)
         kind = CMD_NONE;
      else if (addr)
         kind = CMD_PORT1;
      else if (sel_bits[1])
         kind = CMD_START;
      else if (!sel_bits[0])
         kind = CMD_EOI;
      else
         kind = CMD_RDSEL;
   end

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LINE_W    = 3,
   parameter bit IS_MASTER = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_kind_e         kind,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_q,
   output logic              edge_q,
   output logic              cascade_q,
   output logic [DATA_W-1:0] vec_base,
   output logic [DATA_W-1:0] casc_q,
   output logic              auto_eoi_q,
   output logic              rd_req_q,
   output icw_st_e           stage_q
);

   localparam int VB_W = DATA_W - LINE_W;

   logic [VB_W-1:0]   vb_hi_q;
   logic              want_four_q;
   logic [DATA_W-1:0] casc_word;

   // The cascade word keeps every bit on a master and only the ID on a slave.
   generate
      if (IS_MASTER) begin : g_master
         assign casc_word = wdata;
      end else begin : g_slave
         assign casc_word = {{VB_W{1'b0}}, wdata[LINE_W-1:0]};
      end
   endgenerate

   assign vec_base = {vb_hi_q, {LINE_W{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q      <= '0;
         edge_q      <= 1'b0;
         cascade_q   <= 1'b0;
         vb_hi_q     <= '0;
         casc_q      <= '0;
         auto_eoi_q  <= 1'b0;
         rd_req_q    <= 1'b1;
         want_four_q <= 1'b0;
         stage_q     <= ST_IDLE;
      end else begin
         case (kind)
            CMD_START: begin
               mask_q      <= '0;
               edge_q      <= wdata[3];
               cascade_q   <= ~wdata[1];
               want_four_q <= wdata[0];
               if (!wdata[0]) auto_eoi_q <= 1'b0;
               stage_q     <= ST_VEC;
            end
            CMD_RDSEL: begin
               if (wdata[1]) rd_req_q <= wdata[0];
            end
            CMD_PORT1: begin
               case (stage_q)
                  ST_IDLE: mask_q <= wdata;
                  ST_VEC: begin
                     vb_hi_q <= wdata[DATA_W-1:LINE_W];
                     if (cascade_q) begin
                        stage_q <= ST_CASC;
                     end else begin
                        casc_q  <= '0;
                        stage_q <= ST_IDLE;
                     end
                  end
                  ST_CASC: begin
                     casc_q  <= casc_word;
                     stage_q <= want_four_q ? ST_FOUR : ST_IDLE;
                  end
                  ST_FOUR: begin
                     auto_eoi_q <= wdata[1];
                     stage_q    <= ST_IDLE;
                  end
                  default: stage_q <= ST_IDLE;
               endcase
            end
            default: ;
         endcase
      end
   end

   a_r2_start_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_START) |=> (mask_q == '0 && stage_q == ST_VEC));

   a_r3_no_four_no_auto: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_START && !wdata[0]) |=> !auto_eoi_q);

   a_r4_casc_stage_needs_cascade: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == ST_CASC) |-> cascade_q);

   a_r6_four_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_PORT1 && stage_q == ST_FOUR) |=>
         (stage_q == ST_IDLE && auto_eoi_q == $past(wdata[1])));

   a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_PORT1 && stage_q == ST_IDLE) |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/pic_eoi_gen.sv
module pic_eoi_gen
   import pic_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int LINE_W = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_kind_e         kind,
   input  logic [2:0]        sub,
   input  logic [LINE_W-1:0] line_sel,
   input  logic [LINES-1:0]  isr_vec,
   output logic              eoi_stb,
   output logic [LINE_W-1:0] eoi_line
);

   logic [LINE_W-1:0] top_line;
   logic              any_hit;
   logic              line_hit;

   // Highest-numbered set in-service bit.
   always_comb begin
      top_line = '0;
      for (int i = 0; i < LINES; i++) begin
         if (isr_vec[i]) top_line = LINE_W'(i);
      end
   end

   assign any_hit  = (kind == CMD_EOI) && (sub == SUB_EOI_ANY) && (|isr_vec);
   assign line_hit = (kind == CMD_EOI) && (sub == SUB_EOI_LINE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eoi_stb  <= 1'b0;
         eoi_line <= '0;
      end else begin
         eoi_stb <= any_hit | line_hit;
         if (line_hit)
            eoi_line <= line_sel;
         else if (any_hit)
            eoi_line <= top_line;
      end
   end

   a_r8_empty_isr_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_EOI && sub == SUB_EOI_ANY && isr_vec == '0) |=> !eoi_stb);

   a_r8_highest_line: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_EOI && sub == SUB_EOI_ANY && isr_vec != '0) |=>
         (eoi_stb && (($past(isr_vec) >> eoi_line) == LINES'(1))));

   a_r9_line_field: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_EOI && sub == SUB_EOI_LINE) |=>
         (eoi_stb && eoi_line == $past(line_sel)));

   a_r10_other_sub_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_EOI && sub != SUB_EOI_ANY && sub != SUB_EOI_LINE) |=> !eoi_stb);

endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
   import pic_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LINES     = 8,
   parameter bit IS_MASTER = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [LINES-1:0]  req_vec,
   input  logic [LINES-1:0]  isr_vec,
   output logic [DATA_W-1:0] irq_mask,
   output logic              edge_mode,
   output logic              cascade_mode,
   output logic [DATA_W-1:0] vec_base,
   output logic [DATA_W-1:0] casc_bits,
   output logic              auto_eoi,
   output logic [1:0]        icw_stage,
   output logic              eoi_stb,
   output logic [2:0]        eoi_line
);

   localparam int LINE_W = $clog2(LINES);

   // Command fields sit at fixed bit positions of a byte with eight lines.
   generate
      if (DATA_W != 8 || LINES != 8) begin : g_bad_cfg
         $error("pic_cmd_seq: DATA_W and LINES must both be 8");
      end
   endgenerate

   cmd_kind_e kind;
   icw_st_e   stage;
   logic      rd_req;

   pic_wr_decode u_dec (
      .we       (bus_we),
      .addr     (bus_addr),
      .sel_bits (bus_wdata[4:3]),
      .kind     (kind)
   );

   pic_init_seq #(
      .DATA_W    (DATA_W),
      .LINE_W    (LINE_W),
      .IS_MASTER (IS_MASTER)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .wdata      (bus_wdata),
      .mask_q     (irq_mask),
      .edge_q     (edge_mode),
      .cascade_q  (cascade_mode),
      .vec_base   (vec_base),
      .casc_q     (casc_bits),
      .auto_eoi_q (auto_eoi),
      .rd_req_q   (rd_req),
      .stage_q    (stage)
   );

   pic_eoi_gen #(
      .LINES  (LINES),
      .LINE_W (LINE_W)
   ) u_eoi (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .sub      (bus_wdata[7:5]),
      .line_sel (bus_wdata[LINE_W-1:0]),
      .isr_vec  (isr_vec),
      .eoi_stb  (eoi_stb),
      .eoi_line (eoi_line)
   );

   assign icw_stage = stage;
   assign bus_rdata = bus_addr ? irq_mask : (rd_req ? req_vec : isr_vec);

   a_r11_select_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != CMD_RDSEL) |=> $stable(rd_req));

   a_r4_single_skips_cascade: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_PORT1 && stage == ST_VEC && !cascade_mode) |=>
         (stage == ST_IDLE && casc_bits == '0));

endmodule

// File: tb/pic_cmd_seq_tb.sv
module pic_cmd_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] req_vec = '0;
   logic [7:0] isr_vec = '0;

   logic [7:0] bus_rdata, irq_mask, vec_base, casc_bits;
   logic       edge_mode, cascade_mode, auto_eoi, eoi_stb;
   logic [1:0] icw_stage;
   logic [2:0] eoi_line;

   logic [7:0] s_rdata, s_mask, s_vec, s_casc;
   logic       s_edge, s_cascade, s_auto, s_stb;
   logic [1:0] s_stage;
   logic [2:0] s_line;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   pic_cmd_seq #(.IS_MASTER(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_vec(req_vec),
      .isr_vec(isr_vec), .irq_mask(irq_mask), .edge_mode(edge_mode),
      .cascade_mode(cascade_mode), .vec_base(vec_base), .casc_bits(casc_bits),
      .auto_eoi(auto_eoi), .icw_stage(icw_stage), .eoi_stb(eoi_stb),
      .eoi_line(eoi_line)
   );

   pic_cmd_seq #(.IS_MASTER(1'b0)) dut_slv_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(s_rdata), .req_vec(req_vec),
      .isr_vec(isr_vec), .irq_mask(s_mask), .edge_mode(s_edge),
      .cascade_mode(s_cascade), .vec_base(s_vec), .casc_bits(s_casc),
      .auto_eoi(s_auto), .icw_stage(s_stage), .eoi_stb(s_stb),
      .eoi_line(s_line)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // One write; returns at the negedge after the capturing posedge.
   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      req_vec = 8'hA5;
      chk("R1 mask", irq_mask, 8'h00);
      chk("R1 stage", {6'b0, icw_stage}, 8'h00);
      chk("R1 flags", {3'b0, edge_mode, cascade_mode, auto_eoi, eoi_stb, 1'b0}, 8'h00);
      chk("R1 vec/casc", vec_base | casc_bits, 8'h00);
      rd(1'b0, v);
      chk("R1 R12 reads request", v, 8'hA5);
   endtask

   task automatic t_mask();
      logic [7:0] v;
      wr(1'b1, 8'h3C);
      chk("R7 mask load", irq_mask, 8'h3C);
      chk("R7 stage idle", {6'b0, icw_stage}, 8'h00);
      rd(1'b1, v);
      chk("R12 read mask", v, 8'h3C);
   endtask

   task automatic t_single();
      wr(1'b0, 8'h1B);  // edge, single, fourth wanted
      chk("R2 mask cleared", irq_mask, 8'h00);
      chk("R2 edge", {7'b0, edge_mode}, 8'h01);
      chk("R2 single", {7'b0, cascade_mode}, 8'h00);
      chk("R2 stage", {6'b0, icw_stage}, 8'h01);
      wr(1'b1, 8'h47);
      chk("R4 vector base", vec_base, 8'h40);
      chk("R4 casc cleared", casc_bits, 8'h00);
      chk("R4 skip to idle", {6'b0, icw_stage}, 8'h00);
      chk("R4 mask untouched", irq_mask, 8'h00);
      wr(1'b1, 8'h81);
      chk("R7 mask after burst", irq_mask, 8'h81);
   endtask

   task automatic t_cascade_four();
      wr(1'b0, 8'h11);  // level, cascade, fourth wanted
      chk("R2 level", {7'b0, edge_mode}, 8'h00);
      chk("R2 cascade", {7'b0, cascade_mode}, 8'h01);
      chk("R2 mask cleared", irq_mask, 8'h00);
      wr(1'b1, 8'h20);
      chk("R4 vector base", vec_base, 8'h20);
      chk("R4 to cascade stage", {6'b0, icw_stage}, 8'h02);
      wr(1'b1, 8'h84);
      chk("R5 master casc", casc_bits, 8'h84);
      chk("R5 slave id", s_casc, 8'h04);
      chk("R5 to fourth stage", {6'b0, icw_stage}, 8'h03);
      wr(1'b1, 8'h03);
      chk("R6 auto set", {7'b0, auto_eoi}, 8'h01);
      chk("R6 idle", {6'b0, icw_stage}, 8'h00);
      chk("R6 mask untouched", irq_mask, 8'h00);
   endtask

   task automatic t_cascade_three();
      wr(1'b0, 8'h10);  // cascade, no fourth
      chk("R3 auto forced off", {7'b0, auto_eoi}, 8'h00);
      wr(1'b1, 8'h0F);
      chk("R4 base low bits", vec_base, 8'h08);
      wr(1'b1, 8'h0E);
      chk("R5 master casc", casc_bits, 8'h0E);
      chk("R5 slave id", s_casc, 8'h06);
      chk("R5 idle w/o fourth", {6'b0, icw_stage}, 8'h00);
      wr(1'b1, 8'h55);
      chk("R7 mask after burst", irq_mask, 8'h55);
   endtask

   task automatic t_eoi();
      isr_vec = 8'b0010_1001;
      wr(1'b0, 8'h20);
      chk("R8 strobe", {7'b0, eoi_stb}, 8'h01);
      chk("R8 highest line", {5'b0, eoi_line}, 8'h05);
      @(negedge clk);
      chk("R8 single cycle", {7'b0, eoi_stb}, 8'h00);
      isr_vec = 8'h80;
      wr(1'b0, 8'h20);
      chk("R8 line 7", {5'b0, eoi_line}, 8'h07);
      chk("R8 strobe 7", {7'b0, eoi_stb}, 8'h01);
      isr_vec = 8'h00;
      wr(1'b0, 8'h20);
      chk("R8 empty no strobe", {7'b0, eoi_stb}, 8'h00);
      wr(1'b0, 8'h66);
      chk("R9 strobe", {7'b0, eoi_stb}, 8'h01);
      chk("R9 line field", {5'b0, eoi_line}, 8'h06);
      @(negedge clk);
      chk("R9 single cycle", {7'b0, eoi_stb}, 8'h00);
   endtask

   task automatic t_other();
      logic [2:0] subs [6] = '{3'd0, 3'd2, 3'd4, 3'd5, 3'd6, 3'd7};
      isr_vec = 8'hFF;
      for (int i = 0; i < 6; i++) begin
         wr(1'b0, {subs[i], 2'b00, 3'b101});
         chk("R10 no strobe", {7'b0, eoi_stb}, 8'h00);
         chk("R10 mask kept", irq_mask, 8'h55);
         chk("R10 config kept", {2'b0, icw_stage, edge_mode, cascade_mode, auto_eoi, 1'b0}, 8'h04);
      end
   endtask

   task automatic t_rdsel();
      logic [7:0] v;
      req_vec = 8'h5A; isr_vec = 8'hC3;
      wr(1'b0, 8'h0A);
      rd(1'b0, v);
      chk("R11 in-service selected", v, 8'hC3);
      wr(1'b0, 8'h09);
      rd(1'b0, v);
      chk("R11 select kept", v, 8'hC3);
      wr(1'b0, 8'h0B);
      rd(1'b0, v);
      chk("R11 R12 request selected", v, 8'h5A);
      rd(1'b1, v);
      chk("R12 mask read", v, 8'h55);
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog expired (all requirements)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_single();
      t_cascade_four();
      t_cascade_three();
      t_eoi();
      t_other();
      t_rdsel();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule